// File: doc/BRIEF.md
# Dual-Load Address Generation Unit

This block carries out the paired-load slot of a 16-bit DSP instruction word. It looks only at the low byte of the word. When an accepted op arrives, it reads two words from its own data RAM in one step. The first read goes through one of four address pointers, chosen by the op. The second read always goes through the last pointer. Each result lands in the low or high half of one of two auxiliary accumulator registers.

After the reads, both pointers are post-modified. Each pointer is either stepped by one or advanced by its companion index register, and the two choices are made independently. The pointer, index and auxiliary registers live inside the block, as does a small RAM with two read ports. Write ports let the surrounding logic, or a bench, preload the pointers, the indexes and the RAM.

The block accepts an op on a one-cycle strobe. All reads and register writes happen at that clock edge. A done pulse and the new register values show in the following cycle.

Top module: `dual_load_agu`

## Requirements
- R1: An op is accepted only when `op_valid` is high and `op_word[7:6]` equals 2'b11. Any other word, or a word presented while `op_valid` is low, changes no register and raises no done pulse.
- R2: For an accepted op, `done` is high in exactly the one cycle after the accepting clock edge. It is low in the cycle after that unless another op was accepted.
- R3: The first read uses the pointer numbered by `op_word[1:0]` (0..3). The second read uses pointer 3. Both reads use the pointer values from before the op. RAM is addressed by the low `MEM_AW` bits of a pointer.
- R4: `op_word[5]` steers the first read. When it is 0 the data goes to the low half of aux 0 (`aux0[15:0]`); when it is 1 it goes to the high half (`aux0[31:16]`). The other half is unchanged.
- R5: `op_word[4]` steers the second read. When it is 0 the data goes to `aux1[15:0]`; when it is 1 it goes to `aux1[31:16]`. The other half is unchanged.
- R6: When `op_word[2]` is 0 the selected pointer gains 1. When it is 1 the selected pointer gains the index register with the same number.
- R7: When `op_word[3]` is 0 pointer 3 gains 1. When it is 1 pointer 3 gains index register 3.
- R8: When `op_word[1:0]` is 3, both reads use the same address. The final value of pointer 3 is its old value plus the step chosen by `op_word[3]`, and the step chosen by `op_word[2]` is lost.
- R9: All pointer arithmetic is 16 bits wide and wraps modulo 2^16.
- R10: Synchronous reset clears all four pointers, all four index registers, both aux registers and `done` to zero.
- R11: When `reg_wr_en` is high, `reg_wr_data` is written at the clock edge. Selectors 0..3 of `reg_wr_sel` pick pointers 0..3 and selectors 4..7 pick index registers 0..3. When `mem_wr_en` is high, the RAM word at `mem_wr_addr` is written at the clock edge. `ar_bus` shows pointer i at bits [16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe for `op_word` |
| op_word | input | 16 | Instruction word; only the low byte is decoded |
| reg_wr_en | input | 1 | Pointer/index preload enable |
| reg_wr_sel | input | 3 | 0..3 pointer, 4..7 index register |
| reg_wr_data | input | 16 | Preload value |
| mem_wr_en | input | 1 | RAM write enable |
| mem_wr_addr | input | MEM_AW (8) | RAM write address |
| mem_wr_data | input | 16 | RAM write data |
| done | output | 1 | Pulse in the cycle after an accepted op |
| ar_bus | output | 64 | Four pointers packed, pointer 0 in the low bits |
| aux0 | output | 32 | Aux register 0, {high, low} |
| aux1 | output | 32 | Aux register 1, {high, low} |

## Verification
Every result of an op (the done pulse, both aux halves and all four pointers) is registered at the edge that accepts the op. All of them are therefore due one cycle later. The bench drives the op on a falling edge and samples everything on the next falling edge. It then samples once more, one cycle later, to confirm that `done` has dropped. It sweeps all 64 accepted low-byte values over three preload patterns, one of which forces wraparound. A bench model of the registers and the RAM contents computes the expected results.

// File: rtl/dla_pkg.sv
package dla_pkg;
    localparam int WORD_W    = 16;
    localparam int NUM_PTR   = 4;
    localparam int PTR_SEL_W = $clog2(NUM_PTR);

    typedef logic [WORD_W-1:0] word_t;

    // decoded view of the paired-load slot
    typedef struct packed {
        logic                 hit;
        logic [PTR_SEL_W-1:0] sel;
        logic                 idx_a;
        logic                 idx_b;
        logic                 hi_a;
        logic                 hi_b;
    } slot_t;

    typedef struct packed {
        word_t [NUM_PTR-1:0] ar;
        word_t [NUM_PTR-1:0] ix;
        word_t               ax0_hi;
        word_t               ax0_lo;
        word_t               ax1_hi;
        word_t               ax1_lo;
        logic                done;
    } state_t;
endpackage

// File: rtl/dla_decode.sv
module dla_decode
    import dla_pkg::*;
(
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_word,
    output slot_t             slot
);
    localparam int SEL_LSB   = 0;
    localparam int IDXA_BIT  = 2;
    localparam int IDXB_BIT  = 3;
    localparam int HIB_BIT   = 4;
    localparam int HIA_BIT   = 5;
    localparam int CLASS_LSB = 6;

    logic unused_hi_byte;
    assign unused_hi_byte = ^op_word[WORD_W-1:8];

    always_comb begin
        slot.hit   = op_valid && (op_word[CLASS_LSB +: 2] == 2'b11);
        slot.sel   = op_word[SEL_LSB +: PTR_SEL_W];
        slot.idx_a = op_word[IDXA_BIT];
        slot.idx_b = op_word[IDXB_BIT];
        slot.hi_a  = op_word[HIA_BIT];
        slot.hi_b  = op_word[HIB_BIT];
    end
endmodule

// File: rtl/dla_ram.sv
module dla_ram
    import dla_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [MEM_AW-1:0] rd_addr_a,
    output word_t             rd_data_a,
    input  logic [MEM_AW-1:0] rd_addr_b,
    output word_t             rd_data_b
);
    localparam int DEPTH = 1 << MEM_AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/dla_postmod.sv
module dla_postmod
    import dla_pkg::*;
(
    input  word_t base,
    input  word_t index,
    input  logic  use_index,
    output word_t next
);
    localparam word_t ONE = word_t'(1);

    always_comb next = base + (use_index ? index : ONE);
endmodule

// File: rtl/dual_load_agu.sv
module dual_load_agu
    import dla_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [15:0]          op_word,
    input  logic                 reg_wr_en,
    input  logic [2:0]           reg_wr_sel,
    input  logic [15:0]          reg_wr_data,
    input  logic                 mem_wr_en,
    input  logic [MEM_AW-1:0]    mem_wr_addr,
    input  logic [15:0]          mem_wr_data,
    output logic                 done,
    output logic [63:0]          ar_bus,
    output logic [31:0]          aux0,
    output logic [31:0]          aux1
);
    localparam int LAST_PTR = NUM_PTR - 1;

    state_t st_d, st_q;
    slot_t  slot;
    word_t  addr_a, addr_b, data_a, data_b, next_a, next_b;

    dla_decode u_dec (
        .op_valid (op_valid),
        .op_word  (op_word),
        .slot     (slot)
    );

    assign addr_a = st_q.ar[slot.sel];
    assign addr_b = st_q.ar[LAST_PTR];

    dla_ram #(.MEM_AW(MEM_AW)) u_ram (
        .clk       (clk),
        .wr_en     (mem_wr_en),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .rd_addr_a (addr_a[MEM_AW-1:0]),
        .rd_data_a (data_a),
        .rd_addr_b (addr_b[MEM_AW-1:0]),
        .rd_data_b (data_b)
    );

    dla_postmod u_mod_a (
        .base      (addr_a),
        .index     (st_q.ix[slot.sel]),
        .use_index (slot.idx_a),
        .next      (next_a)
    );

    dla_postmod u_mod_b (
        .base      (addr_b),
        .index     (st_q.ix[LAST_PTR]),
        .use_index (slot.idx_b),
        .next      (next_b)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (reg_wr_en) begin
            if (reg_wr_sel[PTR_SEL_W]) st_d.ix[reg_wr_sel[PTR_SEL_W-1:0]] = reg_wr_data;
            else                       st_d.ar[reg_wr_sel[PTR_SEL_W-1:0]] = reg_wr_data;
        end
        if (slot.hit) begin
            if (slot.hi_a) st_d.ax0_hi = data_a;
            else           st_d.ax0_lo = data_a;
            if (slot.hi_b) st_d.ax1_hi = data_b;
            else           st_d.ax1_lo = data_b;
            // first pointer first; the fixed pointer's update wins on collision
            st_d.ar[slot.sel] = next_a;
            st_d.ar[LAST_PTR] = next_b;
            st_d.done         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done   = st_q.done;
    assign ar_bus = st_q.ar;
    assign aux0   = {st_q.ax0_hi, st_q.ax0_lo};
    assign aux1   = {st_q.ax1_hi, st_q.ax1_lo};
endmodule

// File: rtl/dla_checker.sv
module dla_checker #(
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [15:0]       op_word,
    input logic              reg_wr_en,
    input logic              done,
    input logic [63:0]       ar_bus,
    input logic [31:0]       aux0,
    input logic [31:0]       aux1
);
    logic accepted;
    assign accepted = op_valid && (op_word[7:6] == 2'b11);

    AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (rst) accepted |=> done); // R2
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) !accepted |=> !done); // R1
    AST_AUX_HOLD: assert property (@(posedge clk) disable iff (rst) !accepted |=> ($stable(aux0) && $stable(aux1))); // R1
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst) (!accepted && !reg_wr_en) |=> $stable(ar_bus)); // R1
    AST_LAST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (accepted && !op_word[3] && !reg_wr_en) |=> (ar_bus[63:48] == $past(ar_bus[63:48]) + 16'd1)); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (ar_bus == '0 && aux0 == '0 && aux1 == '0 && !done)); // R10
endmodule

bind dual_load_agu dla_checker #(.MEM_AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_word   (op_word),
    .reg_wr_en (reg_wr_en),
    .done      (done),
    .ar_bus    (ar_bus),
    .aux0      (aux0),
    .aux1      (aux1)
);

// File: tb/tb_dual_load_agu.sv
`timescale 1ns/1ps
module tb_dual_load_agu;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [15:0]   op_word = '0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_wr_sel = '0;
    logic [15:0]   reg_wr_data = '0;
    logic          mem_wr_en = 1'b0;
    logic [AW-1:0] mem_wr_addr = '0;
    logic [15:0]   mem_wr_data = '0;
    logic          done;
    logic [63:0]   ar_bus;
    logic [31:0]   aux0, aux1;

    always #4 clk = ~clk;

    dual_load_agu #(.MEM_AW(AW)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .ar_bus(ar_bus), .aux0(aux0), .aux1(aux1)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] m_ar [4];
    logic [15:0] m_ix [4];
    logic [15:0] m_a0h, m_a0l, m_a1h, m_a1l;

    function automatic logic [15:0] memv(logic [15:0] a);
        return {a[7:0], ~a[7:0]} ^ 16'h5A3C;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin m_ar[i] = '0; m_ix[i] = '0; end
        m_a0h = '0; m_a0l = '0; m_a1h = '0; m_a1l = '0;
    endtask

    task automatic check_state(string tag_a, string tag_b, logic [1:0] sel);
        for (int i = 0; i < 4; i++) begin
            if (i == 3) chk((sel == 2'd3) ? "R8 ptr3" : "R7 ptr3", ar_bus[48 +: 16], m_ar[3]);
            else chk($sformatf("R6 ptr%0d", i), ar_bus[16*i +: 16], m_ar[i]);
        end
        chk(tag_a, aux0, {m_a0h, m_a0l});
        chk(tag_b, aux1, {m_a1h, m_a1l});
    endtask

    task automatic wr_reg(logic [2:0] sel, logic [15:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel[2]) m_ix[sel[1:0]] = val; else m_ar[sel[1:0]] = val;
    endtask

    task automatic run_op(logic [15:0] w);
        logic hit;
        logic [1:0] s;
        logic [15:0] da, db, na, nb;
        hit = (w[7:6] == 2'b11);
        s   = w[1:0];
        @(negedge clk);
        op_valid = 1'b1; op_word = w;
        if (hit) begin
            da = memv(m_ar[s]);
            db = memv(m_ar[3]);
            na = m_ar[s] + (w[2] ? m_ix[s] : 16'd1);
            nb = m_ar[3] + (w[3] ? m_ix[3] : 16'd1);
            if (w[5]) m_a0h = da; else m_a0l = da;
            if (w[4]) m_a1h = db; else m_a1l = db;
            m_ar[s] = na;
            m_ar[3] = nb;
        end
        @(negedge clk);
        op_valid = 1'b0;
        if (hit) begin
            chk("R2 done", {31'd0, done}, 32'd1);
            check_state("R3 R4 aux0", "R3 R5 aux1", s);
        end else begin
            chk("R1 done", {31'd0, done}, 32'd0);
            check_state("R1 aux0", "R1 aux1", 2'd0);
        end
        @(negedge clk);
        chk("R2 done drop", {31'd0, done}, 32'd0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 ptrs", ar_bus[31:0], 32'd0);
        chk("R10 ptrs hi", ar_bus[63:32], 32'd0);
        chk("R10 aux0", aux0, 32'd0);
        chk("R10 aux1", aux1, 32'd0);
        chk("R10 done", {31'd0, done}, 32'd0);

        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            mem_wr_en = 1'b1; mem_wr_addr = AW'(a); mem_wr_data = memv(16'(a));
        end
        @(negedge clk);
        mem_wr_en = 1'b0;

        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 4; i++) begin
                case (p)
                    0: begin wr_reg(3'(i), 16'(16'h0003 + 16*i)); wr_reg(3'(4 + i), 16'(i + 2)); end
                    1: begin wr_reg(3'(i), 16'(16'h1234 + 16'h0101*i)); wr_reg(3'(4 + i), 16'(16'hFFFE - i)); end
                    default: begin wr_reg(3'(i), 16'(16'hFFF0 + i)); wr_reg(3'(4 + i), 16'(7*(i + 1))); end
                endcase
            end
            for (int i = 0; i < 4; i++) chk("R11 preload", {16'd0, ar_bus[16*i +: 16]}, {16'd0, m_ar[i]});
            for (int lb = 8'hC0; lb <= 8'hFF; lb++) run_op({8'(lb * 3 + p), 8'(lb)});
        end

        // rejected words and a strobe-less hit word
        run_op(16'h0000);
        run_op(16'h3F7C);
        run_op(16'h12BF);
        run_op(16'hAA40);
        @(negedge clk);
        op_word = 16'h00C5;
        @(negedge clk);
        op_word = 16'h0000;
        chk("R1 no strobe done", {31'd0, done}, 32'd0);
        check_state("R1 no strobe aux0", "R1 no strobe aux1", 2'd0);

        // wrap at the top of the 16-bit range
        wr_reg(3'd0, 16'hFFFF);
        wr_reg(3'd3, 16'hFFFE);
        wr_reg(3'd7, 16'h0005);
        run_op(16'h00C8);
        chk("R9 ptr0 wrap", {16'd0, ar_bus[15:0]}, 32'h0000_0000);
        chk("R9 ptr3 wrap", {16'd0, ar_bus[63:48]}, 32'h0000_0003);

        // mid-run reset then index-mode op: zero indexes keep pointers at zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R10 mid ptrs", ar_bus[31:0], 32'd0);
        chk("R10 mid aux0", aux0, 32'd0);
        run_op(16'h00CC);
        chk("R10 ix cleared ptr0", {16'd0, ar_bus[15:0]}, 32'd0);
        chk("R10 ix cleared ptr3", {16'd0, ar_bus[63:48]}, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule